// File: doc/BRIEF.md
# Enhanced Memory Protection Permission Checker

This block decides whether a single memory access is allowed. It looks at a bank of protection entries. For each entry the caller supplies a configuration byte and two precomputed flags: one says the access lies above the entry's lower bound, the other says it lies below the upper bound. Address range decoding happens outside the block. Together with the requesting privilege (machine or lower) and the requested read/write/execute bits, the block returns the permission set that applies and a grant bit. The logic is purely combinational.

Three global controls shape the result, and they matter only while the enhanced-mode enable is high. A lockdown control replaces the classic "machine mode bypasses unlocked entries" rule with fixed permission tables, one for machine mode and one for lower privilege. A whitelist control makes machine mode fail closed whenever no entry covers the access. When several entries cover the access, the lowest-numbered one decides. An access that straddles an entry's boundary is refused.

Top module: `epmp_chk_top`

## Requirements
- R1: Configuration byte layout: bit0 = R, bit1 = W, bit2 = X, bits[4:3] = match mode (00 = off), bit7 = lock. An entry takes part in the decision only when its match mode is not off. It fully covers the access only when both its bound flags are high. Permission vectors on the ports use bit0 = R, bit1 = W, bit2 = X.
- R2: With lockdown inactive, a covering entry gives an unlocked machine-mode access RWX. In every other case (locked entry, or lower privilege) it gives the entry's own R/W/X bits.
- R3: With lockdown active, machine mode uses the index {lock,R,W,X} (lock is the MSB) as follows. Index 2, 3 or 14 gives RW. Index 11 or 13 gives RX. Index 12 or 15 gives R. Index 9 or 10 gives X. Every other index gives nothing.
- R4: With lockdown active, lower privilege uses the same index as follows. Index 7 gives RWX. Index 5 gives RX. Index 3 or 6 gives RW. Index 2, 4 or 15 gives R. Index 1, 10 or 11 gives X. Every other index gives nothing.
- R5: Among the entries that take part and have at least one bound flag high, the lowest-numbered one alone decides the result.
- R6: If that deciding entry has exactly one bound flag high, the access is refused: grant 0 and allowed set 0.
- R7: If no entry decides and the whitelist control is active, the access is refused for every privilege, with allowed set 0.
- R8: If no entry decides, whitelist is inactive and lockdown is active, a machine-mode request without X is granted with allowed set RW. Any other request is refused with allowed set 0.
- R9: If no entry decides and neither control is active, machine mode gets RWX and is granted, and lower privilege is refused with allowed set 0.
- R10: While the enhanced-mode enable is low, the lockdown and whitelist inputs have no effect on either output.
- R11: When a covering entry decides, grant is high exactly when the requested bits are a subset of the allowed set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| req_perm_i | input | 3 | Requested permissions (bit0 R, bit1 W, bit2 X) |
| m_mode_i | input | 1 | High for a machine-mode access |
| cfg_i | input | 8*NUM_ENTRIES | Configuration bytes, entry i in bits [8i+7:8i] |
| lo_hit_i | input | NUM_ENTRIES | Per-entry flag: access at or above the lower bound |
| hi_hit_i | input | NUM_ENTRIES | Per-entry flag: access at or below the upper bound |
| enh_en_i | input | 1 | Enhanced-mode enable |
| lockdown_i | input | 1 | Lockdown control |
| whitelist_i | input | 1 | Machine-mode whitelist control |
| allow_o | output | 3 | Permission set that applies to this access |
| grant_o | output | 1 | Access granted |

## Verification
There is no stored state, so a fault in the decode shows up at the ports in the same cycle as the stimulus that exposes it. A wrong table row would go unnoticed unless that exact {lock,R,W,X} index is presented in the matching privilege and lockdown setting. For that reason, all sixteen indices are swept in both privileges with lockdown on and off. A priority or partial-cover fault only shows when two entries overlap, or when the lowest entry straddles a boundary while a higher entry covers the access fully. Both patterns are driven on purpose.

// File: rtl/epmp_chk_pkg.sv
package epmp_chk_pkg;
  typedef logic [2:0] perm_t;

  localparam int unsigned PB_R = 0;
  localparam int unsigned PB_W = 1;
  localparam int unsigned PB_X = 2;
  localparam int unsigned CB_L = 7;
  localparam int unsigned CB_MODE = 3;

  localparam perm_t P_NONE = 3'b000;
  localparam perm_t P_R    = 3'b001;
  localparam perm_t P_RW   = 3'b011;
  localparam perm_t P_X    = 3'b100;
  localparam perm_t P_RX   = 3'b101;
  localparam perm_t P_RWX  = 3'b111;

  // lockdown permission decode, idx = {L,R,W,X}
  function automatic perm_t lockdown_perm(input logic m_mode, input logic [3:0] idx);
    perm_t p;
    p = P_NONE;
    if (m_mode) begin
      unique case (idx)
        4'd2, 4'd3, 4'd14:   p = P_RW;
        4'd9, 4'd10:         p = P_X;
        4'd11, 4'd13:        p = P_RX;
        4'd12, 4'd15:        p = P_R;
        default:             p = P_NONE;
      endcase
    end else begin
      unique case (idx)
        4'd1, 4'd10, 4'd11:  p = P_X;
        4'd2, 4'd4, 4'd15:   p = P_R;
        4'd3, 4'd6:          p = P_RW;
        4'd5:                p = P_RX;
        4'd7:                p = P_RWX;
        default:             p = P_NONE;
      endcase
    end
    return p;
  endfunction
endpackage

// File: rtl/epmp_chk_entry.sv
module epmp_chk_entry
  import epmp_chk_pkg::*;
(
  input  logic [7:0] cfg_i,
  input  logic       lo_hit_i,
  input  logic       hi_hit_i,
  input  logic       lockdown_i,
  input  logic       m_mode_i,
  output logic       engaged_o,
  output logic       full_o,
  output perm_t      perm_o
);
  logic       active;
  logic [3:0] idx;
  perm_t      own;

  assign active    = cfg_i[CB_MODE +: 2] != 2'b00;
  assign engaged_o = active && (lo_hit_i || hi_hit_i);
  assign full_o    = active && lo_hit_i && hi_hit_i;
  assign own       = cfg_i[2:0];
  assign idx       = {cfg_i[CB_L], cfg_i[PB_R], cfg_i[PB_W], cfg_i[PB_X]};

  always_comb begin
    if (lockdown_i)
      perm_o = lockdown_perm(m_mode_i, idx);
    else if (m_mode_i && !cfg_i[CB_L])
      perm_o = P_RWX;
    else
      perm_o = own;
  end

  always_comb begin
    // R3
    if (lockdown_i && m_mode_i)
      m_no_rwx_chk: assert (perm_o != P_RWX);
    // R4
    if (lockdown_i && !m_mode_i && perm_o[PB_W])
      u_w_needs_r_chk: assert (perm_o[PB_R]);
  end
endmodule

// File: rtl/epmp_chk_prio.sv
module epmp_chk_prio #(
  parameter int unsigned NUM_ENTRIES = 8
) (
  input  logic [NUM_ENTRIES-1:0] req_i,
  output logic [NUM_ENTRIES-1:0] sel_o,
  output logic                   any_o
);
  logic [NUM_ENTRIES:0] blocked;

  assign blocked[0] = 1'b0;
  for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_chain
    assign sel_o[i]       = req_i[i] && !blocked[i];
    assign blocked[i + 1] = blocked[i] || req_i[i];
  end
  assign any_o = blocked[NUM_ENTRIES];

  always_comb begin
    // R5
    sel_onehot_chk: assert ($onehot0(sel_o));
  end
endmodule

// File: rtl/epmp_chk_dflt.sv
module epmp_chk_dflt
  import epmp_chk_pkg::*;
(
  input  logic  whitelist_i,
  input  logic  lockdown_i,
  input  logic  m_mode_i,
  input  perm_t req_i,
  output perm_t perm_o,
  output logic  ok_o
);
  always_comb begin
    perm_o = P_NONE;
    ok_o   = 1'b0;
    if (whitelist_i) begin
      perm_o = P_NONE;
      ok_o   = 1'b0;
    end else if (lockdown_i) begin
      if (m_mode_i && !req_i[PB_X]) begin
        perm_o = P_RW;
        ok_o   = 1'b1;
      end
    end else if (m_mode_i) begin
      perm_o = P_RWX;
      ok_o   = 1'b1;
    end
  end
endmodule

// File: rtl/epmp_chk_top.sv
module epmp_chk_top
  import epmp_chk_pkg::*;
#(
  parameter int unsigned NUM_ENTRIES = 8
) (
  input  logic [2:0]               req_perm_i,
  input  logic                     m_mode_i,
  input  logic [8*NUM_ENTRIES-1:0] cfg_i,
  input  logic [NUM_ENTRIES-1:0]   lo_hit_i,
  input  logic [NUM_ENTRIES-1:0]   hi_hit_i,
  input  logic                     enh_en_i,
  input  logic                     lockdown_i,
  input  logic                     whitelist_i,
  output logic [2:0]               allow_o,
  output logic                     grant_o
);
  logic                   lockdown_eff, whitelist_eff;
  logic [NUM_ENTRIES-1:0] engaged, full, sel;
  perm_t                  perm [NUM_ENTRIES];
  logic                   any_engaged, sel_full, dflt_ok;
  perm_t                  sel_perm, dflt_perm;

  assign lockdown_eff  = enh_en_i && lockdown_i;
  assign whitelist_eff = enh_en_i && whitelist_i;

  for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_ent
    epmp_chk_entry u_ent (
      .cfg_i      (cfg_i[8*i +: 8]),
      .lo_hit_i   (lo_hit_i[i]),
      .hi_hit_i   (hi_hit_i[i]),
      .lockdown_i (lockdown_eff),
      .m_mode_i   (m_mode_i),
      .engaged_o  (engaged[i]),
      .full_o     (full[i]),
      .perm_o     (perm[i])
    );
  end

  epmp_chk_prio #(.NUM_ENTRIES(NUM_ENTRIES)) u_prio (
    .req_i (engaged),
    .sel_o (sel),
    .any_o (any_engaged)
  );

  epmp_chk_dflt u_dflt (
    .whitelist_i (whitelist_eff),
    .lockdown_i  (lockdown_eff),
    .m_mode_i    (m_mode_i),
    .req_i       (req_perm_i),
    .perm_o      (dflt_perm),
    .ok_o        (dflt_ok)
  );

  always_comb begin
    sel_perm = P_NONE;
    sel_full = 1'b0;
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      if (sel[i]) begin
        sel_perm = perm[i];
        sel_full = full[i];
      end
    end
  end

  always_comb begin
    if (!any_engaged) begin
      allow_o = dflt_perm;
      grant_o = dflt_ok;
    end else if (!sel_full) begin
      allow_o = P_NONE;
      grant_o = 1'b0;
    end else begin
      allow_o = sel_perm;
      grant_o = (req_perm_i & ~sel_perm) == 3'b000;
    end
  end

  always_comb begin
    // R7
    if (whitelist_eff && !any_engaged)
      wl_deny_chk: assert (!grant_o && allow_o == P_NONE);
    // R6
    if (any_engaged && !sel_full)
      partial_deny_chk: assert (!grant_o && allow_o == P_NONE);
    // R11
    if (grant_o)
      grant_subset_chk: assert ((req_perm_i & ~allow_o) == 3'b000);
  end
endmodule

// File: tb/epmp_chk_top_tb_top.sv
module epmp_chk_top_tb_top;
  localparam int N = 8;

  localparam logic [2:0] M_TBL [16] = '{3'b000, 3'b000, 3'b011, 3'b011,
                                        3'b000, 3'b000, 3'b000, 3'b000,
                                        3'b000, 3'b100, 3'b100, 3'b101,
                                        3'b001, 3'b101, 3'b011, 3'b001};
  localparam logic [2:0] U_TBL [16] = '{3'b000, 3'b100, 3'b001, 3'b011,
                                        3'b001, 3'b101, 3'b011, 3'b111,
                                        3'b000, 3'b000, 3'b100, 3'b100,
                                        3'b000, 3'b000, 3'b000, 3'b001};

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic [2:0]     req_perm;
  logic           m_mode, enh_en, lockdown, whitelist;
  logic [8*N-1:0] cfg;
  logic [N-1:0]   lo_hit, hi_hit;
  logic [2:0]     allow;
  logic           grant;

  epmp_chk_top #(.NUM_ENTRIES(N)) dut_i (
    .req_perm_i (req_perm), .m_mode_i (m_mode), .cfg_i (cfg),
    .lo_hit_i (lo_hit), .hi_hit_i (hi_hit), .enh_en_i (enh_en),
    .lockdown_i (lockdown), .whitelist_i (whitelist),
    .allow_o (allow), .grant_o (grant)
  );

  int errors = 0;
  int checks = 0;
  logic [2:0] exp_allow_q[$];
  logic       exp_grant_q[$];
  string      tag_q[$];

  function automatic logic [7:0] mk(input logic l, input logic [1:0] md, input logic [2:0] xwr);
    return {l, 2'b00, md, xwr};
  endfunction

  function automatic logic [3:0] ref_out(input logic [2:0] rq, input logic m,
      input logic [8*N-1:0] c, input logic [N-1:0] lo, input logic [N-1:0] hi,
      input logic en, input logic ld, input logic wl);
    int hit;
    logic [7:0] e;
    logic [2:0] al;
    logic ld_e, wl_e;
    hit = -1;
    ld_e = en & ld;
    wl_e = en & wl;
    for (int i = N - 1; i >= 0; i--)
      if (c[8*i+3 +: 2] != 2'b00 && (lo[i] || hi[i])) hit = i;
    if (hit < 0) begin
      if (wl_e) return 4'b0000;
      if (ld_e) return (m && !rq[2]) ? 4'b1011 : 4'b0000;
      return m ? 4'b1111 : 4'b0000;
    end
    if (!(lo[hit] && hi[hit])) return 4'b0000;
    e = c[8*hit +: 8];
    if (ld_e) al = m ? M_TBL[{e[7], e[0], e[1], e[2]}] : U_TBL[{e[7], e[0], e[1], e[2]}];
    else      al = (m && !e[7]) ? 3'b111 : e[2:0];
    return {((rq & ~al) == 3'b000), al};
  endfunction

  task automatic apply(input logic [2:0] rq, input logic m, input logic [8*N-1:0] c,
      input logic [N-1:0] lo, input logic [N-1:0] hi, input logic en,
      input logic ld, input logic wl, input string tag);
    logic [3:0] r;
    @(negedge clk);
    req_perm = rq; m_mode = m; cfg = c; lo_hit = lo; hi_hit = hi;
    enh_en = en; lockdown = ld; whitelist = wl;
    r = ref_out(rq, m, c, lo, hi, en, ld, wl);
    exp_allow_q.push_back(r[2:0]);
    exp_grant_q.push_back(r[3]);
    tag_q.push_back(tag);
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      if (exp_allow_q.size() > 0) begin
        logic [2:0] ea;
        logic eg;
        string t;
        ea = exp_allow_q.pop_front();
        eg = exp_grant_q.pop_front();
        t  = tag_q.pop_front();
        checks++;
        if (allow !== ea || grant !== eg) begin
          errors++;
          $display("FAIL %s: allow=%b grant=%b expected allow=%b grant=%b", t, allow, grant, ea, eg);
        end
      end
    end
  end

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        errors++;
        checks++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    logic [8*N-1:0] c;
    req_perm = 3'b000; m_mode = 1'b0; cfg = '0; lo_hit = '0; hi_hit = '0;
    enh_en = 1'b0; lockdown = 1'b0; whitelist = 1'b0;

    // R9 idle state: no entries active
    apply(3'b001, 1'b1, '0, '0, '0, 1'b0, 1'b0, 1'b0, "R9 idle machine");
    apply(3'b001, 1'b0, '0, '0, '0, 1'b0, 1'b0, 1'b0, "R9 idle lower");
    // R1 off entry is ignored even when covered
    c = '0; c[7:0] = mk(1'b0, 2'b00, 3'b000);
    apply(3'b001, 1'b0, c, 8'h01, 8'h01, 1'b0, 1'b0, 1'b0, "R1 off entry");
    // R2 legacy rules
    c = '0; c[23:16] = mk(1'b0, 2'b11, 3'b001);
    apply(3'b010, 1'b1, c, 8'h04, 8'h04, 1'b0, 1'b0, 1'b0, "R2 machine unlocked");
    apply(3'b010, 1'b0, c, 8'h04, 8'h04, 1'b0, 1'b0, 1'b0, "R2 lower");
    apply(3'b001, 1'b0, c, 8'h04, 8'h04, 1'b0, 1'b0, 1'b0, "R11 lower subset");
    c[23:16] = mk(1'b1, 2'b01, 3'b101);
    apply(3'b010, 1'b1, c, 8'h04, 8'h04, 1'b0, 1'b0, 1'b0, "R2 machine locked");
    apply(3'b101, 1'b1, c, 8'h04, 8'h04, 1'b0, 1'b0, 1'b0, "R11 machine locked subset");
    // R5 priority
    c = '0; c[15:8] = mk(1'b0, 2'b10, 3'b001); c[31:24] = mk(1'b0, 2'b10, 3'b111);
    apply(3'b011, 1'b0, c, 8'h0A, 8'h0A, 1'b0, 1'b0, 1'b0, "R5 lowest entry wins");
    // R6 partial on lower entry blocks full higher entry
    c = '0; c[7:0] = mk(1'b0, 2'b11, 3'b111); c[23:16] = mk(1'b0, 2'b11, 3'b111);
    apply(3'b001, 1'b1, c, 8'h05, 8'h04, 1'b0, 1'b0, 1'b0, "R6 partial lo only");
    apply(3'b001, 1'b1, c, 8'h04, 8'h05, 1'b1, 1'b1, 1'b0, "R6 partial hi only");
    // R3 / R4 sweep of every index
    for (int idx = 0; idx < 16; idx++) begin
      c = '0;
      c[15:8] = mk(idx[3], 2'b11, {idx[0], idx[1], idx[2]});
      apply(3'b001, 1'b1, c, 8'h02, 8'h02, 1'b1, 1'b1, 1'b0, "R3 machine table");
      apply(3'b100, 1'b1, c, 8'h02, 8'h02, 1'b1, 1'b1, 1'b1, "R3 machine table X");
      apply(3'b001, 1'b0, c, 8'h02, 8'h02, 1'b1, 1'b1, 1'b0, "R4 lower table");
      apply(3'b011, 1'b0, c, 8'h02, 8'h02, 1'b1, 1'b1, 1'b0, "R4 lower table RW");
      apply(3'b001, 1'b1, c, 8'h02, 8'h02, 1'b0, 1'b1, 1'b1, "R10 table idle when disabled");
    end
    // R7 whitelist default
    apply(3'b001, 1'b1, '0, '0, '0, 1'b1, 1'b0, 1'b1, "R7 machine denied");
    apply(3'b000, 1'b1, '0, '0, '0, 1'b1, 1'b1, 1'b1, "R7 machine empty req");
    apply(3'b001, 1'b0, '0, '0, '0, 1'b1, 1'b0, 1'b1, "R7 lower denied");
    // R8 lockdown default
    apply(3'b011, 1'b1, '0, '0, '0, 1'b1, 1'b1, 1'b0, "R8 machine RW");
    apply(3'b101, 1'b1, '0, '0, '0, 1'b1, 1'b1, 1'b0, "R8 machine with X");
    apply(3'b001, 1'b0, '0, '0, '0, 1'b1, 1'b1, 1'b0, "R8 lower");
    // R10 controls ignored when disabled
    apply(3'b111, 1'b1, '0, '0, '0, 1'b0, 1'b1, 1'b1, "R10 default machine");
    c = '0; c[7:0] = mk(1'b0, 2'b11, 3'b001);
    apply(3'b110, 1'b1, c, 8'h01, 8'h01, 1'b0, 1'b1, 1'b0, "R10 legacy entry machine");

    while (exp_allow_q.size() > 0) @(posedge clk);
    @(negedge clk);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule